// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block is the power-management sequencer beside a microcontroller core. While the core runs, a wait-for-interrupt strobe asks the block to sleep. A 3-bit level field then picks how deep the sleep goes, and a regulator-ready flag is checked first. The block drives the enables for the CPU clock, main clock, bus clock, generic clock and each oscillator. It also drives a 2-bit regulator mode, a 2-bit NVM power state and a 3-bit code for the current mode.

Each sleep level accepts only its own class of wake event. The shallow levels wake on interrupts. The deeper levels wake only on a reset indication of their own kind. While the block sleeps, peripherals may ask for the bus clock, the generic clock or an oscillator, and they get it without waking the CPU. On wake, the block brings up power first, then the clocks, and the CPU clock last.

Top module: `lp_sleep_top`

## Requirements
- R1: `sleepLevel` codes are 0 = IDLE, 1 = STANDBY, 2 = HIBERNATE, 3 = BACKUP and 4 = OFF. A `wfiReq` seen at a clock edge in the active mode enters the chosen level at that edge. Codes 5 to 7 are ignored, and `wfiReq` outside the active mode is ignored. `curMode` reads 0 for active, 1 to 5 for IDLE to OFF, and 6 for the two wake steps.
- R2: STANDBY, HIBERNATE and BACKUP are entered only while `sleepReady` is 1. If it is 0, the request is dropped and the block stays active. IDLE and OFF do not depend on `sleepReady`.
- R3: In IDLE the CPU clock is off, the main and generic clocks stay on, and the bus clock follows `busClkReq`. `regMode` is 0 (active) and `nvmState` is 0 (active).
- R4: IDLE is left on `syncIrq`, `syncIrqStby` or `asyncIrq`.
- R5: In STANDBY the CPU and main clocks are off, `regMode` is 1 (low-power) and `nvmState` is 1 (ultra-low-power). The block wakes on `asyncIrq` or `syncIrqStby`. A plain `syncIrq` does not wake it.
- R6: In HIBERNATE every clock and oscillator is off, `regMode` is 1 and `nvmState` is 2 (ultra-low-power+). Only `hibWake` ends it.
- R7: In BACKUP, `regMode` is 2 (backup regulator) and `nvmState` is 3 (off), and only `bkupWake` ends it. In OFF, `regMode` is 3 and `nvmState` is 3, and only `extWake` ends it. In both, every clock and oscillator is off.
- R8: A wake event at an edge gives this sequence. One step has regulator and NVM active with the clocks still as in sleep. The next step has main, bus and generic clocks on with the CPU clock off. One cycle later the active mode returns with the CPU clock on.
- R9: Oscillator bit i, in the active mode, in IDLE and in the clock step of a wake, is on when `oscOnDemand[i]` is 0 or `oscReq[i]` is 1. In STANDBY it is on when `oscReq[i]` is 1, or when `oscRunStby[i]` is 1 and `oscOnDemand[i]` is 0. In deeper levels it is off.
- R10: In IDLE and STANDBY, `busClkReq` turns on the bus clock, and in STANDBY `genClkReq` turns on the generic clock. This happens in the same cycle, and neither request changes `curMode` or the CPU clock.
- R11: While `rstN` is 0 the block is active: every clock enable is 1, `regMode` and `nvmState` are 0, and `curMode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wfiReq | input | 1 | Wait-for-interrupt strobe from the CPU |
| sleepLevel | input | 3 | Requested sleep depth |
| sleepReady | input | 1 | Main regulator low-power mode has settled |
| syncIrq | input | 1 | Bus-clocked interrupt |
| syncIrqStby | input | 1 | Bus-clocked interrupt from a run-in-standby peripheral |
| asyncIrq | input | 1 | Asynchronous interrupt or event |
| hibWake | input | 1 | Hibernate-reset indication |
| bkupWake | input | 1 | Backup-reset indication |
| extWake | input | 1 | External reset indication |
| busClkReq | input | 1 | Peripheral request for the bus clock in sleep |
| genClkReq | input | 1 | Peripheral request for the generic clock in sleep |
| oscReq | input | NUM_OSC | Per-oscillator run request |
| oscRunStby | input | NUM_OSC | Per-oscillator run-in-standby setting |
| oscOnDemand | input | NUM_OSC | Per-oscillator on-demand setting |
| cpuClkEn | output | 1 | CPU clock enable |
| mainClkEn | output | 1 | Main clock enable |
| busClkEn | output | 1 | Bus clock enable |
| genClkEn | output | 1 | Generic clock enable |
| oscEn | output | NUM_OSC | Per-oscillator enable |
| regMode | output | 2 | Regulator mode: 0 active, 1 low-power, 2 backup, 3 off |
| nvmState | output | 2 | NVM state: 0 active, 1 ultra-low-power, 2 ultra-low-power+, 3 off |
| curMode | output | 3 | Current mode code |

## Verification
Mode changes are registered. An accepted `wfiReq` or a qualifying wake event shows up on `curMode` and on the power outputs in the cycle after the edge that samples it. The two wake steps and the return to active then follow one edge apart. The request-driven enables (`busClkEn`, `genClkEn`, `oscEn`) are combinational and answer in the cycle the request is applied. The bench therefore changes inputs mid-cycle. A behavioural reference steps at each rising edge, and the bench compares every output 5 ns after that edge, so that the registered and the combinational results are both settled.

// File: rtl/lp_sleep_pkg.sv
package lp_sleep_pkg;

  localparam int LVL_W  = 3;
  localparam int MODE_W = 3;

  // Sleep level request codes
  localparam logic [LVL_W-1:0] LVL_IDLE = 3'd0;
  localparam logic [LVL_W-1:0] LVL_STBY = 3'd1;
  localparam logic [LVL_W-1:0] LVL_HIB  = 3'd2;
  localparam logic [LVL_W-1:0] LVL_BKUP = 3'd3;
  localparam logic [LVL_W-1:0] LVL_OFF  = 3'd4;

  // Reported mode codes
  localparam logic [MODE_W-1:0] MODE_ACTIVE = 3'd0;
  localparam logic [MODE_W-1:0] MODE_WAKE   = 3'd6;

  // Regulator mode codes
  localparam logic [1:0] REG_ACTIVE = 2'd0;
  localparam logic [1:0] REG_LP     = 2'd1;
  localparam logic [1:0] REG_BKUP   = 2'd2;
  localparam logic [1:0] REG_OFF    = 2'd3;

  // NVM state codes
  localparam logic [1:0] NVM_ACTIVE = 2'd0;
  localparam logic [1:0] NVM_ULP    = 2'd1;
  localparam logic [1:0] NVM_ULPP   = 2'd2;
  localparam logic [1:0] NVM_OFF    = 2'd3;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_SLEEP = 2'd1,
    PH_PWR   = 2'd2,
    PH_CLK   = 2'd3
  } phaseE;

  typedef struct packed {
    logic  latchLvl;
    phaseE phase;
  } ctrlStrobeT;

endpackage

// File: rtl/lp_sleep_ctrl.sv
module lp_sleep_ctrl
  import lp_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wfiReq,
  input  logic       entryOk,
  input  logic       wakeHit,
  output ctrlStrobeT strobe
);

  phaseE phaseQ;
  phaseE phaseD;
  logic  enterNow;

  assign enterNow = (phaseQ == PH_RUN) && wfiReq && entryOk;

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      PH_RUN:   if (enterNow) phaseD = PH_SLEEP;
      PH_SLEEP: if (wakeHit)  phaseD = PH_PWR;
      PH_PWR:   phaseD = PH_CLK;
      PH_CLK:   phaseD = PH_RUN;
      default:  phaseD = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_RUN;
    else       phaseQ <= phaseD;
  end

  assign strobe.latchLvl = enterNow;
  assign strobe.phase    = phaseQ;

endmodule

// File: rtl/lp_sleep_dp.sv
module lp_sleep_dp
  import lp_sleep_pkg::*;
#(
  parameter int NUM_OSC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strobe,
  input  logic [LVL_W-1:0]   sleepLevel,
  input  logic               sleepReady,
  input  logic               syncIrq,
  input  logic               syncIrqStby,
  input  logic               asyncIrq,
  input  logic               hibWake,
  input  logic               bkupWake,
  input  logic               extWake,
  input  logic               busClkReq,
  input  logic               genClkReq,
  input  logic [NUM_OSC-1:0] oscReq,
  input  logic [NUM_OSC-1:0] oscRunStby,
  input  logic [NUM_OSC-1:0] oscOnDemand,
  output logic               entryOk,
  output logic               wakeHit,
  output logic               cpuClkEn,
  output logic               mainClkEn,
  output logic               busClkEn,
  output logic               genClkEn,
  output logic [NUM_OSC-1:0] oscEn,
  output logic [1:0]         regMode,
  output logic [1:0]         nvmState,
  output logic [MODE_W-1:0]  curMode
);

  typedef enum logic [1:0] {OSC_ACT, OSC_STBY, OSC_STOP} oscRuleE;

  logic [LVL_W-1:0] lvlQ;
  logic             needsReady;
  logic             lvlValid;
  oscRuleE          oscRule;

  // Held sleep level, captured on the entry strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lvlQ <= LVL_IDLE;
    else if (strobe.latchLvl) lvlQ <= sleepLevel;
  end

  // Entry qualification
  assign lvlValid   = (sleepLevel <= LVL_OFF);
  assign needsReady = (sleepLevel == LVL_STBY) || (sleepLevel == LVL_HIB) ||
                      (sleepLevel == LVL_BKUP);
  assign entryOk    = lvlValid && (!needsReady || sleepReady);

  // Wake qualification by held level
  always_comb begin
    unique case (lvlQ)
      LVL_IDLE: wakeHit = syncIrq | syncIrqStby | asyncIrq;
      LVL_STBY: wakeHit = syncIrqStby | asyncIrq;
      LVL_HIB:  wakeHit = hibWake;
      LVL_BKUP: wakeHit = bkupWake;
      LVL_OFF:  wakeHit = extWake;
      default:  wakeHit = 1'b0;
    endcase
  end

  // Domain decode
  always_comb begin
    cpuClkEn  = 1'b0;
    mainClkEn = 1'b1;
    busClkEn  = 1'b1;
    genClkEn  = 1'b1;
    regMode   = REG_ACTIVE;
    nvmState  = NVM_ACTIVE;
    curMode   = MODE_ACTIVE;
    oscRule   = OSC_ACT;
    unique case (strobe.phase)
      PH_RUN: begin
        cpuClkEn = 1'b1;
      end
      PH_CLK: begin
        curMode = MODE_WAKE;
      end
      PH_SLEEP, PH_PWR: begin
        curMode = (strobe.phase == PH_PWR) ? MODE_WAKE : (lvlQ + 3'd1);
        unique case (lvlQ)
          LVL_IDLE: begin
            busClkEn = busClkReq;
          end
          LVL_STBY: begin
            mainClkEn = 1'b0;
            busClkEn  = busClkReq;
            genClkEn  = genClkReq;
            oscRule   = OSC_STBY;
            regMode   = REG_LP;
            nvmState  = NVM_ULP;
          end
          LVL_HIB: begin
            mainClkEn = 1'b0;
            busClkEn  = 1'b0;
            genClkEn  = 1'b0;
            oscRule   = OSC_STOP;
            regMode   = REG_LP;
            nvmState  = NVM_ULPP;
          end
          LVL_BKUP: begin
            mainClkEn = 1'b0;
            busClkEn  = 1'b0;
            genClkEn  = 1'b0;
            oscRule   = OSC_STOP;
            regMode   = REG_BKUP;
            nvmState  = NVM_OFF;
          end
          default: begin
            mainClkEn = 1'b0;
            busClkEn  = 1'b0;
            genClkEn  = 1'b0;
            oscRule   = OSC_STOP;
            regMode   = REG_OFF;
            nvmState  = NVM_OFF;
          end
        endcase
        // power is restored in the first wake step
        if (strobe.phase == PH_PWR) begin
          regMode  = REG_ACTIVE;
          nvmState = NVM_ACTIVE;
        end
      end
      default: cpuClkEn = 1'b0;
    endcase
  end

  // Per-oscillator enable
  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    always_comb begin
      unique case (oscRule)
        OSC_ACT:  oscEn[g] = oscReq[g] | ~oscOnDemand[g];
        OSC_STBY: oscEn[g] = oscReq[g] | (oscRunStby[g] & ~oscOnDemand[g]);
        default:  oscEn[g] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/lp_sleep_top.sv
module lp_sleep_top
  import lp_sleep_pkg::*;
#(
  parameter int NUM_OSC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wfiReq,
  input  logic [2:0]         sleepLevel,
  input  logic               sleepReady,
  input  logic               syncIrq,
  input  logic               syncIrqStby,
  input  logic               asyncIrq,
  input  logic               hibWake,
  input  logic               bkupWake,
  input  logic               extWake,
  input  logic               busClkReq,
  input  logic               genClkReq,
  input  logic [NUM_OSC-1:0] oscReq,
  input  logic [NUM_OSC-1:0] oscRunStby,
  input  logic [NUM_OSC-1:0] oscOnDemand,
  output logic               cpuClkEn,
  output logic               mainClkEn,
  output logic               busClkEn,
  output logic               genClkEn,
  output logic [NUM_OSC-1:0] oscEn,
  output logic [1:0]         regMode,
  output logic [1:0]         nvmState,
  output logic [2:0]         curMode
);

  ctrlStrobeT strobe;
  logic       entryOk;
  logic       wakeHit;

  lp_sleep_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wfiReq  (wfiReq),
    .entryOk (entryOk),
    .wakeHit (wakeHit),
    .strobe  (strobe)
  );

  lp_sleep_dp #(.NUM_OSC(NUM_OSC)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sleepLevel  (sleepLevel),
    .sleepReady  (sleepReady),
    .syncIrq     (syncIrq),
    .syncIrqStby (syncIrqStby),
    .asyncIrq    (asyncIrq),
    .hibWake     (hibWake),
    .bkupWake    (bkupWake),
    .extWake     (extWake),
    .busClkReq   (busClkReq),
    .genClkReq   (genClkReq),
    .oscReq      (oscReq),
    .oscRunStby  (oscRunStby),
    .oscOnDemand (oscOnDemand),
    .entryOk     (entryOk),
    .wakeHit     (wakeHit),
    .cpuClkEn    (cpuClkEn),
    .mainClkEn   (mainClkEn),
    .busClkEn    (busClkEn),
    .genClkEn    (genClkEn),
    .oscEn       (oscEn),
    .regMode     (regMode),
    .nvmState    (nvmState),
    .curMode     (curMode)
  );

endmodule

// File: rtl/lp_sleep_chk.sv
module lp_sleep_chk #(
  parameter int NUM_OSC = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               wfiReq,
  input logic [2:0]         sleepLevel,
  input logic               sleepReady,
  input logic               syncIrq,
  input logic               syncIrqStby,
  input logic               asyncIrq,
  input logic               hibWake,
  input logic               bkupWake,
  input logic               extWake,
  input logic               cpuClkEn,
  input logic               mainClkEn,
  input logic [NUM_OSC-1:0] oscEn,
  input logic [1:0]         regMode,
  input logic [1:0]         nvmState,
  input logic [2:0]         curMode
);

  p_cpu_off_asleep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (curMode >= 3'd1 && curMode <= 3'd5) |-> !cpuClkEn);

  p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd0 && wfiReq && !sleepReady &&
     (sleepLevel == 3'd1 || sleepLevel == 3'd2 || sleepLevel == 3'd3))
    |=> curMode == 3'd0);

  p_idle_wake_r4: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd1 && (syncIrq || syncIrqStby || asyncIrq)) |=> curMode == 3'd6);

  p_stby_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd2 && !asyncIrq && !syncIrqStby) |=> curMode == 3'd2);

  p_stby_power_r5: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd2) |-> (regMode == 2'd1 && nvmState == 2'd1 && !mainClkEn));

  p_hib_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd3 && !hibWake) |=> curMode == 3'd3);

  p_hib_dark_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd3) |-> (oscEn == '0 && !mainClkEn));

  p_bkup_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd4 && !bkupWake) |=> curMode == 3'd4);

  p_off_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd5 && !extWake) |=> curMode == 3'd5);

  p_cpu_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClkEn) |-> ($past(mainClkEn) && $past(regMode) == 2'd0 &&
                         $past(curMode) == 3'd6));

endmodule

bind lp_sleep_top lp_sleep_chk #(.NUM_OSC(NUM_OSC)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wfiReq      (wfiReq),
  .sleepLevel  (sleepLevel),
  .sleepReady  (sleepReady),
  .syncIrq     (syncIrq),
  .syncIrqStby (syncIrqStby),
  .asyncIrq    (asyncIrq),
  .hibWake     (hibWake),
  .bkupWake    (bkupWake),
  .extWake     (extWake),
  .cpuClkEn    (cpuClkEn),
  .mainClkEn   (mainClkEn),
  .oscEn       (oscEn),
  .regMode     (regMode),
  .nvmState    (nvmState),
  .curMode     (curMode)
);

// File: tb/test_lp_sleep_top.sv
`timescale 1ns/1ps
module test_lp_sleep_top;

  localparam int NOSC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wfiReq = 0, sleepReady = 0, syncIrq = 0, syncIrqStby = 0, asyncIrq = 0;
  logic hibWake = 0, bkupWake = 0, extWake = 0, busClkReq = 0, genClkReq = 0;
  logic [2:0] sleepLevel = 3'd0;
  logic [NOSC-1:0] oscReq = '0, oscRunStby = '0, oscOnDemand = '0;
  logic cpuClkEn, mainClkEn, busClkEn, genClkEn;
  logic [NOSC-1:0] oscEn;
  logic [1:0] regMode, nvmState;
  logic [2:0] curMode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference state: 0 active, 1 asleep, 2 power step, 3 clock step
  int mPh  = 0;
  int mLvl = 0;

  always #10 clk = ~clk;

  lp_sleep_top #(.NUM_OSC(NOSC)) i_lp_sleep_top (
    .clk(clk), .rstN(rstN), .wfiReq(wfiReq), .sleepLevel(sleepLevel),
    .sleepReady(sleepReady), .syncIrq(syncIrq), .syncIrqStby(syncIrqStby),
    .asyncIrq(asyncIrq), .hibWake(hibWake), .bkupWake(bkupWake), .extWake(extWake),
    .busClkReq(busClkReq), .genClkReq(genClkReq), .oscReq(oscReq),
    .oscRunStby(oscRunStby), .oscOnDemand(oscOnDemand), .cpuClkEn(cpuClkEn),
    .mainClkEn(mainClkEn), .busClkEn(busClkEn), .genClkEn(genClkEn), .oscEn(oscEn),
    .regMode(regMode), .nvmState(nvmState), .curMode(curMode)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mLvl = 0;
    end else begin
      case (mPh)
        0: begin
          int lv;
          bit ok;
          lv = int'(sleepLevel);
          ok = (lv == 0) || (lv == 4) || (lv >= 1 && lv <= 3 && sleepReady);
          if (wfiReq && ok) begin mPh = 1; mLvl = lv; end
        end
        1: begin
          bit w;
          case (mLvl)
            0: w = syncIrq || syncIrqStby || asyncIrq;
            1: w = syncIrqStby || asyncIrq;
            2: w = hibWake;
            3: w = bkupWake;
            default: w = extWake;
          endcase
          if (w) mPh = 2;
        end
        2: mPh = 3;
        default: mPh = 0;
      endcase
    end
  end

  task automatic compare(input string tag);
    logic [2:0] eMode;
    logic eCpu, eMain, eBus, eGen;
    logic [NOSC-1:0] eOsc;
    logic [1:0] eReg, eNvm;
    bit asleep;
    asleep = (mPh == 1) || (mPh == 2);
    eMode = (mPh == 0) ? 3'd0 : (mPh == 1) ? 3'(mLvl + 1) : 3'd6;
    eCpu  = (mPh == 0);
    eMain = asleep ? (mLvl == 0) : 1'b1;
    eBus  = asleep ? ((mLvl <= 1) ? busClkReq : 1'b0) : 1'b1;
    eGen  = asleep ? ((mLvl == 0) ? 1'b1 : (mLvl == 1) ? genClkReq : 1'b0) : 1'b1;
    for (int i = 0; i < NOSC; i++) begin
      if (!asleep || mLvl == 0) eOsc[i] = oscReq[i] || !oscOnDemand[i];
      else if (mLvl == 1)       eOsc[i] = oscReq[i] || (oscRunStby[i] && !oscOnDemand[i]);
      else                      eOsc[i] = 1'b0;
    end
    eReg = 2'd0; eNvm = 2'd0;
    if (mPh == 1) begin
      case (mLvl)
        1: begin eReg = 2'd1; eNvm = 2'd1; end
        2: begin eReg = 2'd1; eNvm = 2'd2; end
        3: begin eReg = 2'd2; eNvm = 2'd3; end
        4: begin eReg = 2'd3; eNvm = 2'd3; end
        default: ;
      endcase
    end
    nChecks++;
    if ({curMode, cpuClkEn, mainClkEn, busClkEn, genClkEn, oscEn, regMode, nvmState} !==
        {eMode, eCpu, eMain, eBus, eGen, eOsc, eReg, eNvm}) begin
      nFails++;
      $display("FAIL %s t=%0t actual mode=%0d cpu=%b main=%b bus=%b gen=%b osc=%b reg=%0d nvm=%0d expected mode=%0d cpu=%b main=%b bus=%b gen=%b osc=%b reg=%0d nvm=%0d",
               tag, $time, curMode, cpuClkEn, mainClkEn, busClkEn, genClkEn, oscEn, regMode, nvmState,
               eMode, eCpu, eMain, eBus, eGen, eOsc, eReg, eNvm);
    end
  endtask

  task automatic tick(input string tag, input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #5;
      compare(tag);
    end
  endtask

  task automatic enter(input logic [2:0] lvl, input string tag);
    sleepLevel = lvl; wfiReq = 1'b1;
    tick(tag);
    wfiReq = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    #15; compare("R11");
    #20; compare("R11");
    rstN = 1'b1;
    tick("R11", 2);

    // R9: oscillator rule while active
    oscOnDemand = 4'b0101; oscReq = 4'b0001; oscRunStby = 4'b0110;
    tick("R9", 2);

    // R3, R10: idle with bus request; R4 wake on syncIrq; R8 sequence
    enter(3'd0, "R1");
    tick("R3", 2);
    busClkReq = 1'b1; tick("R10"); busClkReq = 1'b0; tick("R10");
    syncIrq = 1'b1; tick("R4"); syncIrq = 1'b0;
    tick("R8", 3);

    // R4: idle wake by asyncIrq, then by syncIrqStby
    enter(3'd0, "R1"); tick("R3");
    asyncIrq = 1'b1; tick("R4"); asyncIrq = 1'b0; tick("R8", 3);
    enter(3'd0, "R1");
    syncIrqStby = 1'b1; tick("R4"); syncIrqStby = 1'b0; tick("R8", 3);

    // R2: deep levels refused without ready; R1: reserved codes ignored
    sleepReady = 1'b0;
    enter(3'd1, "R2"); tick("R2");
    enter(3'd2, "R2"); enter(3'd3, "R2"); tick("R2");
    enter(3'd5, "R1"); enter(3'd7, "R1"); tick("R1");

    // R5, R9, R10: standby
    sleepReady = 1'b1;
    enter(3'd1, "R5");
    tick("R9", 2);
    oscReq = 4'b0100; tick("R9");
    genClkReq = 1'b1; busClkReq = 1'b1; tick("R10");
    genClkReq = 1'b0; busClkReq = 1'b0; tick("R10");
    syncIrq = 1'b1; tick("R5", 2); syncIrq = 1'b0;
    hibWake = 1'b1; tick("R5"); hibWake = 1'b0;
    syncIrqStby = 1'b1; tick("R5"); syncIrqStby = 1'b0;
    // R1: wfi during wake steps is ignored
    wfiReq = 1'b1; sleepLevel = 3'd0; tick("R1", 2); wfiReq = 1'b0;
    tick("R8");
    enter(3'd1, "R5"); asyncIrq = 1'b1; tick("R5"); asyncIrq = 1'b0; tick("R8", 3);

    // R6: hibernate
    enter(3'd2, "R6");
    asyncIrq = 1'b1; syncIrq = 1'b1; syncIrqStby = 1'b1; bkupWake = 1'b1; extWake = 1'b1;
    busClkReq = 1'b1; genClkReq = 1'b1; oscReq = 4'b1111;
    tick("R6", 3);
    asyncIrq = 0; syncIrq = 0; syncIrqStby = 0; bkupWake = 0; extWake = 0;
    busClkReq = 0; genClkReq = 0; oscReq = 4'b0001;
    hibWake = 1'b1; tick("R6"); hibWake = 1'b0; tick("R8", 3);

    // R7: backup
    enter(3'd3, "R7");
    hibWake = 1'b1; asyncIrq = 1'b1; extWake = 1'b1; tick("R7", 2);
    hibWake = 0; asyncIrq = 0; extWake = 0;
    bkupWake = 1'b1; tick("R7"); bkupWake = 1'b0; tick("R8", 3);

    // R7: off, entered without ready (R2)
    sleepReady = 1'b0;
    enter(3'd4, "R2");
    hibWake = 1'b1; bkupWake = 1'b1; asyncIrq = 1'b1; tick("R7", 2);
    hibWake = 0; bkupWake = 0; asyncIrq = 0;
    extWake = 1'b1; tick("R7"); extWake = 1'b0; tick("R8", 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule